// File: doc/BRIEF.md
# Valid-Tagged Delay Pipeline with Control-Only Reset

This block delays a data word by a fixed number of clock stages and carries a one-bit valid tag beside it. The tag marks the cycle in which a loaded word reaches the last stage. A load strobe admits the input word into the entry stage. From there the word moves forward one stage on every clock edge, with no stall, until it reaches the output.

Only the valid tag chain is reset. The data registers have no reset connection at all. A synthesis tool can therefore map them onto plain registers or shift-register resources, and the reset does not become an enable term on the data path. Downstream logic must treat the data output as meaningful only while the valid output is high.

A parameter selects how much of the tag chain sees the reset. By default every tag stage clears on reset, so words already in flight are discarded. In the entry-only variant, only the first tag stage is reset. Words that have already moved past the entry still come out, and the reset must be held for at least the pipeline depth to leave the pipeline empty.

Top module: `valid_tag_pipe`

## Requirements
- R1: With the default full-clear setting, a clock edge with `rst` high (synchronous, active high) makes `validOut` 0 after that edge. `validOut` then stays 0 until a word loaded after the release has crossed the whole depth.
- R2: A word present on `dataIn` at an edge where `load` is high and `rst` is low appears on `dataOut` with `validOut` high after exactly DEPTH edges, counting the capture edge.
- R3: `validOut` is high in exactly one cycle per accepted load and in no other cycle.
- R4: Loads on consecutive edges come out on consecutive cycles, in the order they were loaded, with no gap and no reordering.
- R5: An edge with `load` low adds no valid word, whatever value is on `dataIn`.
- R6: A `load` that falls on an edge where `rst` is high is ignored and never produces a valid output word.
- R7: With the full-clear setting, a reset edge discards every word in flight. None of the words loaded before the reset ever shows `validOut` high.
- R8: With the entry-only setting (FLUSH_ALL = 0), the reset clears only the entry tag. Words that were already beyond the entry when the reset began still emerge on schedule. A reset held for DEPTH edges leaves no valid word behind it.
- R9: With DEPTH = 1, `validOut` after an edge equals `load` AND NOT `rst` as sampled on that edge, and `dataOut` holds the word captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset for the valid tag chain only |
| load | input | 1 | Capture strobe for the entry stage |
| dataIn | input | WIDTH | Word to be delayed |
| dataOut | output | WIDTH | Last data stage; meaningful only while `validOut` is high |
| validOut | output | 1 | Tag aligned with the last data stage |

## Verification
The two functions that meet in one cycle are a reset edge and a load edge, together with words already in flight.

The bench asserts `load` on every edge of a reset pulse, including the final reset edge. It also starts a reset in the middle of a burst of back-to-back loads. This drives the same stimulus into a full-clear instance, an entry-only instance and a single-stage instance.

For every edge, the expected tag and word of each instance are computed arithmetically from a recorded history of `rst`, `load` and `dataIn`. A full-clear instance must drop every word that saw any reset edge. An entry-only instance must drop only the words whose capture edge coincided with reset.

// File: rtl/valid_tag_pipe_pkg.sv
package valid_tag_pipe_pkg;

  // Strobes passed from the tag (control) side to the word (data) side.
  typedef struct packed {
    logic capture;   // entry stage takes dataIn on this edge
  } pipeStrobeT;

endpackage

// File: rtl/valid_tag_ctrl.sv
module valid_tag_ctrl
  import valid_tag_pipe_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter bit FLUSH_ALL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  output pipeStrobeT strobe,
  output logic       tagOut
);

  logic tagChain [DEPTH];

  // The entry stage may take any word; only the tag decides whether it counts.
  assign strobe.capture = load;

  generate
    if (FLUSH_ALL) begin : g_clearAll
      // Every tag flop is reset: in-flight words are dropped on reset.
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) tagChain[i] <= 1'b0;
        end else begin
          tagChain[0] <= load;
          for (int i = 1; i < DEPTH; i++) tagChain[i] <= tagChain[i-1];
        end
      end
    end else begin : g_clearEntry
      // Only the entry tag is reset; followers are plain delay flops,
      // kept in a separate process so reset stays off their enable.
      always_ff @(posedge clk) begin
        if (rst) tagChain[0] <= 1'b0;
        else     tagChain[0] <= load;
      end
      if (DEPTH > 1) begin : g_follow
        always_ff @(posedge clk) begin
          for (int i = 1; i < DEPTH; i++) tagChain[i] <= tagChain[i-1];
        end
      end
    end
  endgenerate

  assign tagOut = tagChain[DEPTH-1];

endmodule

// File: rtl/valid_tag_data.sv
module valid_tag_data
  import valid_tag_pipe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  pipeStrobeT       strobe,
  input  logic [WIDTH-1:0] wordIn,
  output logic [WIDTH-1:0] wordOut
);

  logic [WIDTH-1:0] wordStage [DEPTH];

  // Entry stage: no reset, loads only on capture.
  always_ff @(posedge clk) begin
    if (strobe.capture) wordStage[0] <= wordIn;
  end

  // Follower stages: no reset, no enable; a pure shift.
  generate
    if (DEPTH > 1) begin : g_shift
      always_ff @(posedge clk) begin
        for (int i = 1; i < DEPTH; i++) wordStage[i] <= wordStage[i-1];
      end
    end
  endgenerate

  assign wordOut = wordStage[DEPTH-1];

endmodule

// File: rtl/valid_tag_pipe.sv
module valid_tag_pipe
  import valid_tag_pipe_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 8,
  parameter bit FLUSH_ALL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             validOut
);

  pipeStrobeT strobe;

  valid_tag_ctrl #(
    .DEPTH     (DEPTH),
    .FLUSH_ALL (FLUSH_ALL)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .strobe (strobe),
    .tagOut (validOut)
  );

  valid_tag_data #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) data_i (
    .clk     (clk),
    .strobe  (strobe),
    .wordIn  (dataIn),
    .wordOut (dataOut)
  );

endmodule

// File: rtl/valid_tag_pipe_chk.sv
module valid_tag_pipe_chk #(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 8,
  parameter bit FLUSH_ALL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut,
  input logic             validOut
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic          seenReset;
  logic [CW-1:0] sinceReset;
  logic [CW-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenReset  <= 1'b1;
      sinceReset <= '0;
    end else if (sinceReset < CW'(DEPTH)) begin
      sinceReset <= sinceReset + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + CW'(load) - CW'(validOut);
  end

  generate
    if (FLUSH_ALL) begin : g_fullChk
      // R1
      reset_clears_chk: assert property (@(posedge clk) rst |=> !validOut);
      // R1
      quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (seenReset && sinceReset < CW'(DEPTH)) |-> !validOut);
      // R3
      no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        (seenReset && validOut) |-> (inFlight != '0));
      // R4
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        seenReset |-> (inFlight <= CW'(DEPTH)));
    end
    if (DEPTH == 1) begin : g_oneChk
      // R9
      single_stage_chk: assert property (@(posedge clk) disable iff (!seenReset)
        seenReset |=> (validOut == ($past(load) && !$past(rst))));
      // R9
      single_word_chk: assert property (@(posedge clk) disable iff (rst)
        (load && seenReset) |=> (dataOut == $past(dataIn)));
    end
  endgenerate

endmodule

bind valid_tag_pipe valid_tag_pipe_chk #(
  .DEPTH     (DEPTH),
  .WIDTH     (WIDTH),
  .FLUSH_ALL (FLUSH_ALL)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .dataIn   (dataIn),
  .dataOut  (dataOut),
  .validOut (validOut)
);

// File: tb/valid_tag_pipe_tb_top.sv
module valid_tag_pipe_tb_top;

  localparam int W    = 8;
  localparam int D    = 4;
  localparam int HLEN = 2048;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] dataIn = '0;

  logic [W-1:0] outFull, outOne, outEntry;
  logic         vFull, vOne, vEntry;

  int  checks = 0;
  int  errors = 0;
  int  t = 0;
  bit  done = 1'b0;

  bit           hRst  [HLEN];
  bit           hLoad [HLEN];
  logic [W-1:0] hData [HLEN];

  always #2 clk = ~clk;  // 250 MHz

  valid_tag_pipe #(.DEPTH(D), .WIDTH(W), .FLUSH_ALL(1'b1)) dut_i (
    .clk(clk), .rst(rst), .load(load), .dataIn(dataIn),
    .dataOut(outFull), .validOut(vFull));

  valid_tag_pipe #(.DEPTH(1), .WIDTH(W), .FLUSH_ALL(1'b1)) dutOne_i (
    .clk(clk), .rst(rst), .load(load), .dataIn(dataIn),
    .dataOut(outOne), .validOut(vOne));

  valid_tag_pipe #(.DEPTH(D), .WIDTH(W), .FLUSH_ALL(1'b0)) dutEntry_i (
    .clk(clk), .rst(rst), .load(load), .dataIn(dataIn),
    .dataOut(outEntry), .validOut(vEntry));

  // Expected tag/word after edge tt for a pipe of given depth and mode.
  function automatic void expectAt(input int depth, input bit all, input int tt,
                                   output bit v, output logic [W-1:0] d);
    int s;
    s = tt - depth + 1;
    v = 1'b0;
    d = '0;
    if (s < 1) return;
    v = hLoad[s] && !hRst[s];
    if (all) begin
      for (int u = s; u <= tt; u++) if (hRst[u]) v = 1'b0;
    end
    d = hData[s];
  endfunction

  task automatic checkOne(input string tag, input string name, input int depth,
                          input bit all, input logic v, input logic [W-1:0] d);
    bit           ev;
    logic [W-1:0] ed;
    expectAt(depth, all, t, ev, ed);
    checks++;
    if (v !== ev) begin
      errors++;
      $display("FAIL %s %s validOut t=%0d actual=%b expected=%b", tag, name, t, v, ev);
    end
    if (ev) begin
      checks++;
      if (d !== ed) begin
        errors++;
        $display("FAIL %s/R2 %s dataOut t=%0d actual=%h expected=%h", tag, name, t, d, ed);
      end
    end
  endtask

  task automatic checkAll(input string tag);
    if (t >= 1) checkOne(tag, "full", D, 1'b1, vFull, outFull);
    // R9: single-stage instance
    if (t >= 1) checkOne(tag, "R9 one", 1, 1'b1, vOne, outOne);
    // R8: entry-only instance, followers settled after DEPTH reset edges
    if (t >= D) checkOne(tag, "R8 entry", D, 1'b0, vEntry, outEntry);
  endtask

  task automatic step(input bit r, input bit l, input string tag);
    rst    = r;
    load   = l;
    dataIn = W'((t + 1) * 29 + 11);
    @(posedge clk);
    t++;
    hRst[t]  = r;
    hLoad[t] = l;
    hData[t] = dataIn;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    @(negedge clk);
    // R1, R6: reset with load pulsing, including on the last reset edge
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R6");
    // R5: idle, loads low
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R5");
    // R2: single word
    step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R2");
    // R4: back-to-back burst
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R4");
    // R3: sweep over every 6-bit load pattern
    for (int p = 0; p < 64; p++) begin
      for (int b = 0; b < 6; b++) step(1'b0, p[b], "R3");
    end
    // R7, R8: reset in mid-burst held DEPTH edges, load kept high
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7");
    for (int i = 0; i < D; i++) step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R8");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R8");
    // R1: reset release with alternating loads afterwards
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 10; i++) step(1'b0, i[0], "R1");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at t=%0d actual=hung expected=finished", t);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule